// File: doc/BRIEF.md
# Configurable GPIO Port with Edge Interrupts

A general-purpose I/O port of `N_PINS` pins. Software configures each pin through a small synchronous register interface. The configuration covers four things:

- direction,
- output level,
- reduced drive strength,
- pull device and polarity, plus interrupt enable.

From that configuration the block drives per-pin pad-control lines: output enable, output value, drive-strength select, pull-up enable and pull-down enable.

One polarity bit does two jobs. With pulls enabled on an input it chooses pull-down over pull-up. With interrupts enabled it chooses the rising edge over the falling edge.

Pad inputs pass through a two-flop synchronizer. A detected edge of the selected polarity sets a sticky per-pin flag, and software clears that flag by writing 1. Edge detection keeps working on pins driven as outputs. The enabled flags are ORed into one interrupt request.

Two parameters cover port variants. `HAS_POL` = 0 makes the polarity register read as zero. `HAS_IRQ` = 0 removes interrupt capability.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every configuration register and every flag is 0, all pad-control outputs are 0 and `irq_o` is 0.
- R2: `pad_oe_o[i]` equals direction bit i (1 = output). `pad_out_o[i]` equals the stored output-level bit i, which is written at address 0.
- R3: `pad_rdrv_o[i]` is 1 only when direction bit i and reduced-drive bit i are both 1. On an input pin the reduced-drive bit has no effect.
- R4: For an input pin with pull enable 1, polarity 0 asserts `pad_pu_o` and polarity 1 asserts `pad_pd_o`. When the pin is an output, or pull enable is 0, both are 0.
- R5: With interrupt enable 1, polarity 1 sets flag i on a rising edge of `pad_i[i]` and polarity 0 sets it on a falling edge. The opposite edge, or interrupt enable 0, leaves the flag clear. The flag is visible 3 clocks after the pad changes.
- R6: Edge detection and flag setting also work on pins whose direction is output.
- R7: Flags are sticky. Writing 1 to a bit at address 6 clears that flag, and writing 0 leaves it unchanged.
- R8: `irq_o` is the OR over all pins of (flag AND interrupt enable).
- R9: Reading address 0 returns the synchronized pad value for input pins and the stored output bit for output pins. Read data appears on `rdata_o` one clock after the read request.
- R10: Register map:
  - 0 data,
  - 1 direction,
  - 2 reduced drive,
  - 3 pull enable,
  - 4 polarity,
  - 5 interrupt enable,
  - 6 flags.
  Address 7 reads 0.
- R11: With `HAS_POL` = 0, polarity reads 0 and enabled pulls are always pull-ups. With `HAS_IRQ` = 0, interrupt enable and flags read 0 and `irq_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | N_PINS | Write data |
| rdata_o | output | N_PINS | Registered read data |
| pad_i | input | N_PINS | Asynchronous pad input levels |
| pad_oe_o | output | N_PINS | Pad output enable |
| pad_out_o | output | N_PINS | Pad output value |
| pad_rdrv_o | output | N_PINS | Reduced drive strength select |
| pad_pu_o | output | N_PINS | Pull-up enable |
| pad_pd_o | output | N_PINS | Pull-down enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A table walks combinations of direction, output level, reduced drive, pull enable and polarity. Together they show that the pull controls follow the polarity bit only on input pins, and that the drive select is masked on input pins.

Edge tests toggle every pin at once under a split polarity setting, so rising-sensitive and falling-sensitive pins see both edge directions in one step. The same edge pattern is repeated with every pin driven as an output.

Further tests separate clear-by-one from write-zero and masking by interrupt enable from flag state. A second instance without polarity or interrupt support shows those bits tied off at the ports.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 3'd0,
    REG_DIR   = 3'd1,
    REG_RDRV  = 3'd2,
    REG_PULL  = 3'd3,
    REG_POL   = 3'd4,
    REG_IRQEN = 3'd5,
    REG_FLAG  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS  = 8,
  parameter bit          HAS_POL = 1'b1,
  parameter bit          HAS_IRQ = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] out_q_o,
  output logic [N_PINS-1:0] dir_q_o,
  output logic [N_PINS-1:0] rdrv_q_o,
  output logic [N_PINS-1:0] pull_q_o,
  output logic [N_PINS-1:0] pol_q_o,
  output logic [N_PINS-1:0] ie_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o  <= '0;
      dir_q_o  <= '0;
      rdrv_q_o <= '0;
      pull_q_o <= '0;
    end else if (wr_i) begin
      case (addr_i)
        REG_DATA: out_q_o  <= wdata_i;
        REG_DIR:  dir_q_o  <= wdata_i;
        REG_RDRV: rdrv_q_o <= wdata_i;
        REG_PULL: pull_q_o <= wdata_i;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_POL) begin : g_pol
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        pol_q_o <= '0;
        else if (wr_i && addr_i == REG_POL) pol_q_o <= wdata_i;
      end
    end else begin : g_no_pol
      assign pol_q_o = '0;
    end

    if (HAS_IRQ) begin : g_ie
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          ie_q_o <= '0;
        else if (wr_i && addr_i == REG_IRQEN) ie_q_o <= wdata_i;
      end
    end else begin : g_no_ie
      assign ie_q_o = '0;
    end
  endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] sync_o,
  output logic [N_PINS-1:0] prev_o
);
  logic [STAGES-1:0][N_PINS-1:0] pipe_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= '0;
        else         pipe_q[s] <= (s == 0) ? pad_i : pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= pipe_q[STAGES-1];
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] sync_i,
  input  logic [N_PINS-1:0] prev_i,
  input  logic [N_PINS-1:0] pol_i,
  input  logic [N_PINS-1:0] ie_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] flag_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] rise, fall, hit;

  assign rise = sync_i & ~prev_i;
  assign fall = ~sync_i & prev_i;
  // pol=1 selects rising, pol=0 falling
  assign hit  = ie_i & ((pol_i & rise) | (~pol_i & fall));

  // a new edge wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr_i) | hit;
  end

  assign irq_o = |(flag_o & ie_i);
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS  = 8,
  parameter bit          HAS_POL = 1'b1,
  parameter bit          HAS_IRQ = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_rdrv_o,
  output logic [N_PINS-1:0] pad_pu_o,
  output logic [N_PINS-1:0] pad_pd_o,
  output logic              irq_o
);
  logic              wr, rd;
  logic [N_PINS-1:0] out_q, dir_q, rdrv_q, pull_q, pol_q, ie_q;
  logic [N_PINS-1:0] sync_v, prev_v, flag_q, clr_v, rd_mux;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  gpio_cfg_regs #(.N_PINS(N_PINS), .HAS_POL(HAS_POL), .HAS_IRQ(HAS_IRQ)) u_cfg (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i, .wdata_i,
    .out_q_o(out_q), .dir_q_o(dir_q), .rdrv_q_o(rdrv_q),
    .pull_q_o(pull_q), .pol_q_o(pol_q), .ie_q_o(ie_q)
  );

  gpio_in_sync #(.N_PINS(N_PINS), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .pad_i, .sync_o(sync_v), .prev_o(prev_v)
  );

  assign clr_v = (wr && addr_i == REG_FLAG) ? wdata_i : '0;

  gpio_edge_flags #(.N_PINS(N_PINS)) u_flags (
    .clk_i, .rst_ni, .sync_i(sync_v), .prev_i(prev_v), .pol_i(pol_q),
    .ie_i(ie_q), .clr_i(clr_v), .flag_o(flag_q), .irq_o
  );

  // pad control
  assign pad_oe_o   = dir_q;
  assign pad_out_o  = out_q;
  assign pad_rdrv_o = dir_q & rdrv_q;
  assign pad_pu_o   = ~dir_q & pull_q & ~pol_q;
  assign pad_pd_o   = ~dir_q & pull_q & pol_q;

  always_comb begin
    case (addr_i)
      REG_DATA:  rd_mux = (dir_q & out_q) | (~dir_q & sync_v);
      REG_DIR:   rd_mux = dir_q;
      REG_RDRV:  rd_mux = rdrv_q;
      REG_PULL:  rd_mux = pull_q;
      REG_POL:   rd_mux = pol_q;
      REG_IRQEN: rd_mux = ie_q;
      REG_FLAG:  rd_mux = flag_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter int unsigned N_PINS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [2:0]        addr_i,
  input logic [N_PINS-1:0] wdata_i,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic [N_PINS-1:0] pad_rdrv_o,
  input logic [N_PINS-1:0] pad_pu_o,
  input logic [N_PINS-1:0] pad_pd_o,
  input logic              irq_o,
  input logic [N_PINS-1:0] flag_i,
  input logic [N_PINS-1:0] ie_i
);
  logic [N_PINS-1:0] clr_mask;
  assign clr_mask = (req_i && we_i && addr_i == 3'd6) ? wdata_i : '0;

  // R4
  pull_off_output_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_pu_o | pad_pd_o) & pad_oe_o) == '0);

  // R4
  pull_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_pd_o) == '0);

  // R3
  rdrv_output_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_rdrv_o & ~pad_oe_o) == '0);

  // R8
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flag_i & ie_i) != '0));

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(flag_i) & ~$past(clr_mask)) & ~flag_i) == '0));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.N_PINS(N_PINS)) chk_i (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
  .pad_oe_o, .pad_rdrv_o, .pad_pu_o, .pad_pd_o, .irq_o,
  .flag_i(flag_q), .ie_i(ie_q)
);

// File: tb/gpio_edge_port_tb_top.sv
module gpio_edge_port_tb_top;
  localparam int unsigned N = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [N-1:0] wdata = '0, pad = '1;
  logic [N-1:0] rdata, oe, outv, rdrv, pu, pd;
  logic irq;
  logic [N-1:0] rdata_np, oe_np, out_np, rdrv_np, pu_np, pd_np;
  logic irq_np;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_port #(.N_PINS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .pad_oe_o(oe),
    .pad_out_o(outv), .pad_rdrv_o(rdrv), .pad_pu_o(pu), .pad_pd_o(pd), .irq_o(irq)
  );

  gpio_edge_port #(.N_PINS(N), .HAS_POL(1'b0), .HAS_IRQ(1'b0)) dut_np_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_np), .pad_i(pad), .pad_oe_o(oe_np),
    .pad_out_o(out_np), .pad_rdrv_o(rdrv_np), .pad_pu_o(pu_np), .pad_pd_o(pd_np),
    .irq_o(irq_np)
  );

  // {dir,out,rdrv,pull,pol} -> {oe,out,rdrv,pu,pd}
  localparam logic [9:0] VEC [8] = '{
    10'b00000_00000, 10'b00010_00010, 10'b00011_00001, 10'b01100_01000,
    10'b10010_10000, 10'b11011_11000, 10'b10100_10100, 10'b11111_11100
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    check({oe, outv, rdrv, pu, pd, 7'd0, irq}, '0, "R1 pad outputs");
    rd(3'd1, d); check(d, '0, "R1 dir reset");
    rd(3'd6, d); check(d, '0, "R1 flags reset");
    rd(3'd5, d); check(d, '0, "R1 irq enable reset");

    // R2 R3 R4 table walk
    foreach (VEC[k]) begin
      wr(3'd1, {N{VEC[k][9]}});
      wr(3'd0, {N{VEC[k][8]}});
      wr(3'd2, {N{VEC[k][7]}});
      wr(3'd3, {N{VEC[k][6]}});
      wr(3'd4, {N{VEC[k][5]}});
      settle(1);
      check({oe, outv, rdrv, pu, pd},
            {{N{VEC[k][4]}}, {N{VEC[k][3]}}, {N{VEC[k][2]}}, {N{VEC[k][1]}}, {N{VEC[k][0]}}},
            $sformatf("R2/R3/R4 vector %0d", k));
    end
    wr(3'd1, '0); wr(3'd3, '0); wr(3'd2, '0); wr(3'd0, '0);

    // R9 data read path
    @(negedge clk); pad = 8'hA5;
    settle(3);
    rd(3'd0, d); check(d, 8'hA5, "R9 input pins read pad");
    wr(3'd1, 8'h0F); wr(3'd0, 8'h03);
    rd(3'd0, d); check(d, 8'hA3, "R9 mixed direction read");
    wr(3'd1, 8'h00);

    // R10 unused address
    rd(3'd7, d); check(d, '0, "R10 address 7 reads zero");

    // R5 edge polarity: pins 3:0 rising, 7:4 falling, all toggle
    wr(3'd4, 8'h0F); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
    rd(3'd6, d); check(d, '0, "R5 no flags before edges");
    @(negedge clk); pad = 8'h5A;
    settle(3);
    check(irq, 1'b1, "R5 irq after matching edges");
    rd(3'd6, d); check(d, 8'hAA, "R5 only selected edges set flags");

    // R7 write-one-to-clear
    wr(3'd6, 8'h0A);
    rd(3'd6, d); check(d, 8'hA0, "R7 clear by writing one");
    wr(3'd6, 8'h00);
    rd(3'd6, d); check(d, 8'hA0, "R7 writing zero keeps flags");

    // R8 masking by interrupt enable
    wr(3'd5, 8'h0F); settle(1);
    check(irq, 1'b0, "R8 irq masked");
    wr(3'd5, 8'h20); settle(1);
    check(irq, 1'b1, "R8 irq from enabled flag");
    wr(3'd6, 8'hFF); settle(1);
    check(irq, 1'b0, "R8 irq drops after clear");

    // R5 disabled pins do not flag
    wr(3'd5, 8'h00); wr(3'd4, 8'h00);
    @(negedge clk); pad = 8'h00;
    settle(3);
    rd(3'd6, d); check(d, '0, "R5 enable off leaves flags clear");
    @(negedge clk); pad = 8'h5A;
    settle(3);

    // R6 edges on output pins
    wr(3'd1, 8'hFF); wr(3'd5, 8'hFF);
    @(negedge clk); pad = 8'h00;
    settle(3);
    rd(3'd6, d); check(d, 8'h5A, "R6 falling edges on output pins");
    wr(3'd6, 8'hFF); wr(3'd1, 8'h00);

    // R11 variant without polarity or interrupts
    wr(3'd4, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = 3'd4;
    @(negedge clk); req = 1'b0;
    check(rdata_np, '0, "R11 polarity reads zero");
    check(rdata, 8'hFF, "R11 polarity present on full port");
    check({pu_np, pd_np}, {8'hFF, 8'h00}, "R11 pulls default to pull-up");
    @(negedge clk); pad = 8'hFF;
    settle(3);
    check(irq_np, 1'b0, "R11 no irq without capability");
    @(negedge clk); req = 1'b1; we = 1'b0; addr = 3'd6;
    @(negedge clk); req = 1'b0;
    check(rdata_np, '0, "R11 flags read zero");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule